// File: doc/BRIEF.md
# Memory-Mapped Message Portal Endpoint

This block is a bus slave that carries short messages between a host and hardware through per-method word FIFOs. A host reaches it through a simple 32-bit register port. The port has an address, a write strobe, a read strobe, write data and combinational read data. Hardware reaches it through valid/ready word streams.

Request methods move words from the host to the hardware. Indication methods move words from the hardware to the host. A small bank of control registers reports whether any indication is waiting and which channel to service first. The same bank holds the interrupt enable, a few identification constants, and a 64-bit free-running cycle counter. The host reads that counter coherently as two 32-bit halves.

There is no state machine. Every bus access is decoded in the cycle it is presented. The access takes effect on the next clock edge: a FIFO push, a FIFO pop, an enable update, or a capture of the counter's upper half.

Top module: `msg_portal`

## Requirements
- R1: The window is split into 32-byte slots selected by address bits [ADDR_W-1:5]. Slot 0 holds the control registers. Slot n+1 holds method n. Methods 0..N_REQ-1 are request methods and methods N_REQ..N_REQ+N_IND-1 are indication channels 0..N_IND-1. With the default of two request methods and two indication channels, the slots are 0x20 and 0x40 for requests and 0x60 and 0x80 for indications. Only word-aligned offsets 0x00 and 0x04 inside a method slot are mapped. A read of any other offset, slot or misaligned address returns 0, and a write there has no effect.
- R2: A write to a request slot's offset 0x00 pushes the write data into that method's FIFO, which is FIFO_DEPTH (4) words deep. The hardware receives the words in push order on req_valid/req_data and removes one word per cycle in which both req_valid and req_ready are 1. A write to a full request FIFO is dropped.
- R3: Reading offset 0x04 of a method slot returns bit 0 = 1 when a request FIFO is not full, or when an indication FIFO is not empty. Otherwise bit 0 is 0. Upper bits are 0.
- R4: An indication FIFO accepts a hardware word when ind_valid and ind_ready are both 1, and ind_ready is 1 exactly when the FIFO is not full. Reading offset 0x00 of an indication slot returns the oldest word and removes it. A read of an empty indication FIFO returns 0 and leaves the FIFO unchanged.
- R5: Control offset 0x00 reads 1 when any indication FIFO holds a word. Control offset 0x04 holds an enable bit: a write loads it from write-data bit 0, and a read returns it. The irq output is the AND of the enable bit and the status at offset 0x00. Writes to control offsets other than 0x04 have no effect.
- R6: Control offset 0x0C returns the lowest indication channel number that holds a word, plus one. It returns 0 when no indication channel holds a word.
- R7: Control offset 0x08 returns 1 (tile count), offset 0x10 returns IFACE_ID, and offset 0x14 returns PORTAL_COUNT.
- R8: Reading control offset 0x18 returns the low 32 bits of a 64-bit counter that advances by one every cycle out of reset. The same read captures the counter's high 32 bits. Control offset 0x1C returns the captured high word, which changes only on a read of 0x18.
- R9: During reset the enable bit and the captured high word are 0, all FIFOs are empty, and the counter is loaded with CTR_RST (default 0).
- R10: rdata is 0 whenever rd_en is 0. While rd_en is 1, rdata reflects the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address within the portal window |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; reads with side effects act at the clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Level interrupt |
| req_valid | output | N_REQ | Request word available, one bit per request method |
| req_ready | input | N_REQ | Hardware takes the request word |
| req_data | output | 32*N_REQ | Request words, method i in bits [32i+31:32i] |
| ind_valid | input | N_IND | Hardware offers an indication word |
| ind_ready | output | N_IND | Indication FIFO has room |
| ind_data | input | 32*N_IND | Indication words, channel i in bits [32i+31:32i] |

## Verification
The bench sweeps every slot and offset of a two-request, two-indication map, and every occupancy pattern of the indication channels. A wrong decode would alias method slots, or make unmapped offsets read non-zero. A wrong ready-channel encoder would report the highest channel, or omit the plus-one. It fills each FIFO past its depth and reads an empty indication FIFO. A design that wrapped its pointers on overflow, or popped when empty, would return words out of order or corrupt a later message. The bench starts the cycle counter just below a 32-bit wrap. A design whose high word tracked the live count, instead of the value captured with the low read, would return an advanced value after the wrap.

// File: rtl/portal_pkg.sv
package portal_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_CTRL,
        RGN_REQ_DATA,
        RGN_REQ_STAT,
        RGN_IND_DATA,
        RGN_IND_STAT
    } region_e;
endpackage

// File: rtl/portal_decode.sv
module portal_decode
    import portal_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int N_REQ  = 2,
    parameter int N_IND  = 2,
    localparam int SLOT_W = ADDR_W - 5
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [2:0]        ctrl_sel,
    output logic [SLOT_W-1:0] chan
);
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] method;

    assign slot     = addr[ADDR_W-1:5];
    assign method   = slot - SLOT_W'(1);
    assign ctrl_sel = addr[4:2];

    always_comb begin
        region = RGN_NONE;
        chan   = '0;
        if (addr[1:0] != 2'b00) begin
            region = RGN_NONE;
        end else if (slot == '0) begin
            region = RGN_CTRL;
        end else if (method < SLOT_W'(N_REQ)) begin
            chan = method;
            if (addr[4:2] == 3'd0)      region = RGN_REQ_DATA;
            else if (addr[4:2] == 3'd1) region = RGN_REQ_STAT;
        end else if (method < SLOT_W'(N_REQ + N_IND)) begin
            chan = method - SLOT_W'(N_REQ);
            if (addr[4:2] == 3'd0)      region = RGN_IND_DATA;
            else if (addr[4:2] == 3'd1) region = RGN_IND_STAT;
        end
    end
endmodule

// File: rtl/portal_fifo.sv
module portal_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            if (do_push && !do_pop)      count <= count + CNT_W'(1);
            else if (do_pop && !do_push) count <= count - CNT_W'(1);
        end
    end
endmodule

// File: rtl/portal_cycle_ctr.sv
module portal_cycle_ctr #(
    parameter logic [63:0] CTR_RST = 64'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        capture,
    output logic [31:0] lo,
    output logic [31:0] hi_cap
);
    logic [63:0] cnt;

    assign lo = cnt[31:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= CTR_RST;
            hi_cap <= '0;
        end else begin
            cnt <= cnt + 64'd1;
            if (capture) hi_cap <= cnt[63:32];
        end
    end
endmodule

// File: rtl/msg_portal.sv
module msg_portal
    import portal_pkg::*;
#(
    parameter int          ADDR_W       = 14,
    parameter int          N_REQ        = 2,
    parameter int          N_IND        = 2,
    parameter int          FIFO_DEPTH   = 4,
    parameter logic [31:0] IFACE_ID     = 32'h0000_00A5,
    parameter logic [31:0] PORTAL_COUNT = 32'd1,
    parameter logic [63:0] CTR_RST      = 64'd0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [31:0]             wdata,
    output logic [31:0]             rdata,
    output logic                    irq,
    output logic [N_REQ-1:0]        req_valid,
    input  logic [N_REQ-1:0]        req_ready,
    output logic [32*N_REQ-1:0]     req_data,
    input  logic [N_IND-1:0]        ind_valid,
    output logic [N_IND-1:0]        ind_ready,
    input  logic [32*N_IND-1:0]     ind_data
);
    localparam int SLOT_W = ADDR_W - 5;

    region_e           region;
    logic [2:0]        ctrl_sel;
    logic [SLOT_W-1:0] chan;

    logic [N_REQ-1:0]  req_full, req_empty, req_push, req_pop;
    logic [N_IND-1:0]  ind_full, ind_empty, ind_pop;
    logic [WORD_W-1:0] ind_dout [N_IND];

    logic              irq_en;
    logic              any_ind;
    logic [WORD_W-1:0] ready_num;
    logic              ctr_capture;
    logic [31:0]       ctr_lo, ctr_hi_cap;

    portal_decode #(.ADDR_W(ADDR_W), .N_REQ(N_REQ), .N_IND(N_IND)) u_decode (
        .addr(addr), .region(region), .ctrl_sel(ctrl_sel), .chan(chan)
    );

    for (genvar g = 0; g < N_REQ; g++) begin : g_req
        assign req_push[g]  = wr_en && (region == RGN_REQ_DATA) && (chan == SLOT_W'(g)) && !req_full[g];
        assign req_valid[g] = !req_empty[g];
        assign req_pop[g]   = req_valid[g] && req_ready[g];
        portal_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .push(req_push[g]), .din(wdata),
            .pop(req_pop[g]), .dout(req_data[g*WORD_W +: WORD_W]),
            .full(req_full[g]), .empty(req_empty[g])
        );
    end

    for (genvar g = 0; g < N_IND; g++) begin : g_ind
        assign ind_ready[g] = !ind_full[g];
        assign ind_pop[g]   = rd_en && (region == RGN_IND_DATA) && (chan == SLOT_W'(g)) && !ind_empty[g];
        portal_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .push(ind_valid[g] && ind_ready[g]), .din(ind_data[g*WORD_W +: WORD_W]),
            .pop(ind_pop[g]), .dout(ind_dout[g]),
            .full(ind_full[g]), .empty(ind_empty[g])
        );
    end

    assign any_ind     = |(~ind_empty);
    assign irq         = irq_en && any_ind;
    assign ctr_capture = rd_en && (region == RGN_CTRL) && (ctrl_sel == 3'd6);

    portal_cycle_ctr #(.CTR_RST(CTR_RST)) u_ctr (
        .clk(clk), .rst_n(rst_n), .capture(ctr_capture),
        .lo(ctr_lo), .hi_cap(ctr_hi_cap)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_en <= 1'b0;
        else if (wr_en && (region == RGN_CTRL) && (ctrl_sel == 3'd1))
            irq_en <= wdata[0];
    end

    always_comb begin
        ready_num = '0;
        for (int i = N_IND - 1; i >= 0; i--)
            if (!ind_empty[i]) ready_num = WORD_W'(i + 1);
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (region)
                RGN_CTRL: begin
                    unique case (ctrl_sel)
                        3'd0: rdata = {31'b0, any_ind};
                        3'd1: rdata = {31'b0, irq_en};
                        3'd2: rdata = 32'd1;
                        3'd3: rdata = ready_num;
                        3'd4: rdata = IFACE_ID;
                        3'd5: rdata = PORTAL_COUNT;
                        3'd6: rdata = ctr_lo;
                        3'd7: rdata = ctr_hi_cap;
                    endcase
                end
                RGN_REQ_STAT:
                    for (int i = 0; i < N_REQ; i++)
                        if (chan == SLOT_W'(i)) rdata = {31'b0, !req_full[i]};
                RGN_IND_STAT:
                    for (int i = 0; i < N_IND; i++)
                        if (chan == SLOT_W'(i)) rdata = {31'b0, !ind_empty[i]};
                RGN_IND_DATA:
                    for (int i = 0; i < N_IND; i++)
                        if (chan == SLOT_W'(i) && !ind_empty[i]) rdata = ind_dout[i];
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/portal_checker.sv
module portal_checker #(
    parameter int ADDR_W = 14,
    parameter int N_REQ  = 2,
    parameter int N_IND  = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   addr,
    input logic                wr_en,
    input logic                rd_en,
    input logic [31:0]         wdata,
    input logic [31:0]         rdata,
    input logic                irq,
    input logic [N_REQ-1:0]    req_valid,
    input logic [N_REQ-1:0]    req_ready,
    input logic [32*N_REQ-1:0] req_data,
    input logic [31:0]         ctr_lo,
    input logic [31:0]         ctr_hi_cap
);
    // R5: a read of the ready-channel report while irq is high finds a channel
    assert_irq_has_channel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && rd_en && addr == ADDR_W'('h0C)) |-> (rdata != 32'd0));

    // R5: clearing the enable bit silences irq on the next cycle
    assert_irq_off_after_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'('h04) && !wdata[0]) |=> !irq);

    // R8: the captured high word moves only on a low-word read
    assert_hicap_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd_en && addr == ADDR_W'('h18))) |-> $stable(ctr_hi_cap));

    // R8: the counter advances by one per cycle out of reset
    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ctr_lo == $past(ctr_lo) + 32'd1));

    // R10: no read data without a read strobe
    assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == 32'd0));

    // R2: an offered request word holds until taken
    for (genvar g = 0; g < N_REQ; g++) begin : g_hold
        assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[g] && !req_ready[g]) |=>
                (req_valid[g] && $stable(req_data[g*32 +: 32])));
    end
endmodule

bind msg_portal portal_checker #(.ADDR_W(ADDR_W), .N_REQ(N_REQ), .N_IND(N_IND)) u_portal_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
    .ctr_lo(ctr_lo), .ctr_hi_cap(ctr_hi_cap)
);

// File: tb/tb_msg_portal.sv
module tb_msg_portal;
    localparam int          ADDR_W  = 14;
    localparam int          N_REQ   = 2;
    localparam int          N_IND   = 2;
    localparam int          DEPTH   = 4;
    localparam logic [31:0] ID      = 32'h0000_00A5;
    localparam logic [63:0] CTR_RST = 64'h0000_0001_FFFF_FF00;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [ADDR_W-1:0]   addr = '0;
    logic                wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0]         wdata = '0;
    logic [31:0]         rdata;
    logic                irq;
    logic [N_REQ-1:0]    req_valid;
    logic [N_REQ-1:0]    req_ready = '0;
    logic [32*N_REQ-1:0] req_data;
    logic [N_IND-1:0]    ind_valid = '0;
    logic [N_IND-1:0]    ind_ready;
    logic [32*N_IND-1:0] ind_data = '0;

    int n_chk = 0, n_fail = 0;
    logic [63:0] ref_cnt;
    logic [31:0] rd_val, exp_hi;

    always #10 clk = ~clk;

    always @(posedge clk)
        if (!rst_n) ref_cnt <= CTR_RST;
        else        ref_cnt <= ref_cnt + 64'd1;

    msg_portal #(.ADDR_W(ADDR_W), .N_REQ(N_REQ), .N_IND(N_IND), .FIFO_DEPTH(DEPTH),
                 .IFACE_ID(ID), .PORTAL_COUNT(32'd1), .CTR_RST(CTR_RST)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq),
        .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
        .ind_valid(ind_valid), .ind_ready(ind_ready), .ind_data(ind_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic hw_push(input int ch, input logic [31:0] d, input logic exp_rdy, input string req);
        ind_data[ch*32 +: 32] = d;
        ind_valid[ch] = 1'b1;
        #1 chk(req, 32'(ind_ready[ch]), 32'(exp_rdy));
        @(posedge clk); @(negedge clk);
        ind_valid[ch] = 1'b0;
    endtask

    task automatic hw_pop(input int ch, input logic exp_v, input logic [31:0] exp_d, input string req);
        #1 chk(req, 32'(req_valid[ch]), 32'(exp_v));
        if (exp_v) chk(req, req_data[ch*32 +: 32], exp_d);
        req_ready[ch] = 1'b1;
        @(posedge clk); @(negedge clk);
        req_ready[ch] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 / R10 reset state at the ports
        chk("R10 idle rdata", rdata, 32'd0);
        chk("R9 irq", 32'(irq), 32'd0);
        chk("R9 req_valid", 32'(req_valid), 32'd0);
        chk("R9 ind_ready", 32'(ind_ready), 32'd3);
        rd_chk("R9 status", 'h00, 32'd0);
        rd_chk("R9 enable", 'h04, 32'd0);
        rd_chk("R9 captured high", 'h1C, 32'd0);
        rd_chk("R7 tiles", 'h08, 32'd1);
        rd_chk("R6 none ready", 'h0C, 32'd0);
        rd_chk("R7 id", 'h10, ID);
        rd_chk("R7 portals", 'h14, 32'd1);

        // R8 coherent counter across a low-word wrap
        addr = 'h18; rd_en = 1'b1;
        #1 chk("R8 low word", rdata, ref_cnt[31:0]);
        exp_hi = ref_cnt[63:32];
        @(posedge clk); @(negedge clk); rd_en = 1'b0;
        rd_chk("R8 high capture", 'h1C, exp_hi);
        repeat (300) @(negedge clk);
        rd_chk("R8 high held after wrap", 'h1C, exp_hi);
        addr = 'h18; rd_en = 1'b1;
        #1 chk("R8 low word after wrap", rdata, ref_cnt[31:0]);
        exp_hi = ref_cnt[63:32];
        @(posedge clk); @(negedge clk); rd_en = 1'b0;
        rd_chk("R8 new high capture", 'h1C, exp_hi);
        chk("R8 high advanced", exp_hi, 32'd2);

        // R1 / R3 map sweep: slots 1..7, all word offsets
        for (int s = 1; s < 8; s++) begin
            for (int o = 0; o < 8; o++) begin
                logic [31:0] e;
                e = 32'd0;
                if (o == 1 && s <= N_REQ) e = 32'd1;
                bus_rd(ADDR_W'(s*32 + o*4), rd_val);
                chk(o == 1 ? "R3 slot status" : "R1 map sweep", rd_val, e);
            end
        end
        rd_chk("R1 misaligned", 'h25, 32'd0);

        // R1 / R5 writes with no effect
        bus_wr('h00, 32'd1);
        rd_chk("R5 status write ignored", 'h04, 32'd0);
        bus_wr('hA0, 32'h1234_5678);
        bus_wr('h60, 32'h1234_5678);
        bus_wr('h24, 32'h1234_5678);
        #1 chk("R1 unmapped write req_valid", 32'(req_valid), 32'd0);
        rd_chk("R1 unmapped write ind status", 'h00, 32'd0);

        // R2 / R3 request fill beyond depth, then drain in order
        for (int r = 0; r < N_REQ; r++) begin
            for (int k = 0; k <= DEPTH; k++) begin
                bus_wr(ADDR_W'(32 + r*32), 32'hC0DE_0000 + 32'(r*16 + k));
                rd_chk("R3 request not full", ADDR_W'(36 + r*32), 32'((k + 1) < DEPTH));
            end
            #1 chk("R2 other method idle", 32'(req_valid), 32'(1 << r));
            for (int k = 0; k <= DEPTH; k++)
                hw_pop(r, k < DEPTH, 32'hC0DE_0000 + 32'(r*16 + k), "R2 request order");
            rd_chk("R3 request room again", ADDR_W'(36 + r*32), 32'd1);
        end

        // R4 / R5 / R6 all occupancy patterns of the indication channels
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < N_IND; c++)
                if (m[c]) hw_push(c, 32'hBEEF_0000 + 32'(m*16 + c), 1'b1, "R4 accept");
            rd_chk("R5 status pattern", 'h00, 32'(m != 0));
            rd_chk("R6 lowest ready", 'h0C, m[0] ? 32'd1 : (m[1] ? 32'd2 : 32'd0));
            #1 chk("R5 irq disabled", 32'(irq), 32'd0);
            bus_wr('h04, 32'd1);
            #1 chk("R5 irq enabled", 32'(irq), 32'(m != 0));
            rd_chk("R5 enable readback", 'h04, 32'd1);
            for (int c = 0; c < N_IND; c++)
                rd_chk("R4 indication pop", ADDR_W'(96 + c*32),
                       m[c] ? 32'hBEEF_0000 + 32'(m*16 + c) : 32'd0);
            #1 chk("R5 irq after drain", 32'(irq), 32'd0);
            bus_wr('h04, 32'd0);
        end

        // R4 / R5 / R6 overfill channel 1, drain, then read empty
        for (int k = 0; k <= DEPTH; k++)
            hw_push(1, 32'hFACE_0000 + 32'(k), k < DEPTH, "R4 ready tracks room");
        rd_chk("R3 indication not empty", 'h84, 32'd1);
        rd_chk("R6 channel one", 'h0C, 32'd2);
        bus_wr('h04, 32'd1);
        #1 chk("R5 irq raised", 32'(irq), 32'd1);
        bus_wr('h04, 32'd0);
        #1 chk("R5 irq cleared", 32'(irq), 32'd0);
        for (int k = 0; k < DEPTH; k++)
            rd_chk("R4 indication order", 'h80, 32'hFACE_0000 + 32'(k));
        rd_chk("R4 empty read", 'h80, 32'd0);
        rd_chk("R4 empty read again", 'h80, 32'd0);
        rd_chk("R3 indication empty", 'h84, 32'd0);
        hw_push(1, 32'h600D_0001, 1'b1, "R4 accept after empty read");
        rd_chk("R4 intact after empty read", 'h80, 32'h600D_0001);
        rd_chk("R6 none left", 'h0C, 32'd0);

        finish_run();
    end
endmodule